// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an addressing-mode request into a 32-bit operand address for a processor datapath and keeps the address pointers that those modes step. Eight pointer sets are held inside. Each set has an address register, an offset register and a modifier register, all 32 bits wide. A request carries a mode code, a 3-bit pointer index, a 32-bit extension word, a 15-bit short displacement field and the program counter. The program counter already points at the next instruction.

The effective address is combinational and is valid in the same cycle as the request. Modes that step a pointer write the stepped value back on the next rising clock edge. The modifier register of the selected set picks the stepping arithmetic. It is either plain two's-complement stepping or circular stepping inside an aligned buffer, which makes circular sample buffers possible. Software loads the pointer sets through a single write port.

Top module: `eagu_top`

## Requirements
- R1: Mode code 1 (predecrement). The address register is stepped down by one under its modifier's arithmetic. The stepped value is driven on `ea` in the same cycle and stored on the next edge. The offset register has no effect.
- R2: Mode code 0 (postincrement). The unstepped address register is driven on `ea`. The register is stepped up by one under its modifier's arithmetic and stored on the next edge.
- R3: Mode code 2 (long displacement). `ea` is the address register plus `ext_word`, modulo 2^32. No register changes.
- R4: A modifier of all ones gives linear stepping that wraps at 2^32. Any other value M gives circular stepping with modulus M+1. The buffer size S is the smallest power of two that is at least M+1. The bits of the address above log2(S) are kept. With low part o, a step up gives 0 when o equals M and (o+1) mod S otherwise. A step down gives M when o is 0 and o-1 otherwise.
- R5: Mode code 4 (short PC-relative). `ea` is `pc` plus `short_disp` sign-extended from bit 14. A zero field gives `pc`. No register changes.
- R6: Mode code 3 (long PC-relative). `ea` is `pc` plus `ext_word`. No register changes.
- R7: Mode code 5 (register PC-relative). `ea` is the address register plus `pc`. The modifier and offset registers have no effect, and no register changes.
- R8: Code 6 drives the address register on `ea`. Code 7 drives the offset register on `ea`. Neither code changes any register.
- R9: The write port loads a register on the next edge. `wr_sel` 0 selects the address register, 1 the offset register and 2 the modifier register. `wr_sel` 3 changes nothing. A write to the address register that a stepping mode updates in the same cycle takes priority.
- R10: After reset, every address and offset register is zero and every modifier register is all ones.
- R11: While `req_valid` is low, `ea` is still computed, but no register is stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Qualifies register stepping for the request |
| req_mode | input | 3 | Addressing mode code |
| req_idx | input | 3 | Pointer set index |
| ext_word | input | 32 | Instruction extension word |
| short_disp | input | 15 | Short displacement field, two's complement |
| pc | input | 32 | Address of the next instruction |
| ea | output | 32 | Effective address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register kind selected for writing |
| wr_idx | input | 3 | Pointer set index for writing |
| wr_data | input | 32 | Value to write |

## Verification
The hardest case to reach from the ports is a circular pointer at either wrap point of its buffer. Stepping one value at a time from reset would take many requests to get there. The stimulus instead loads a small modifier and an address whose low part already equals M, or equals zero, through the write port. It then issues postincrement and predecrement requests and reads the pointer back with code 6. Random traffic repeats this by keeping modifiers small and addresses close to buffer edges. It also drives writes that collide with updates to the same pointer.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

   typedef enum logic [2:0] {
      MD_POSTINC = 3'd0,
      MD_PREDEC  = 3'd1,
      MD_LDISP   = 3'd2,
      MD_PCLONG  = 3'd3,
      MD_PCSHORT = 3'd4,
      MD_PCREG   = 3'd5,
      MD_RDADDR  = 3'd6,
      MD_RDOFF   = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_OFF  = 2'd1,
      SEL_MOD  = 2'd2,
      SEL_NONE = 2'd3
   } wsel_e;

   localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/eagu_regbank.sv
module eagu_regbank
   import eagu_pkg::*;
#(
   parameter int unsigned NREG = 8,
   parameter int unsigned AW   = 32,
   localparam int unsigned IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  wsel_e         wr_sel,
   input  logic [IW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic          upd_en,
   input  logic [IW-1:0] upd_idx,
   input  logic [AW-1:0] upd_val,
   input  logic [IW-1:0] rd_idx,
   output logic [AW-1:0] rd_addr,
   output logic [AW-1:0] rd_off,
   output logic [AW-1:0] rd_mod
);

   logic [NREG-1:0][AW-1:0] areg_q;
   logic [NREG-1:0][AW-1:0] oreg_q;
   logic [NREG-1:0][AW-1:0] mreg_q;

   generate
      if (NREG != (1 << IW)) begin : g_chk_nreg
         $error("eagu_regbank: NREG must be a power of two");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         areg_q <= '0;
         oreg_q <= '0;
         mreg_q <= '1;
      end else begin
         if (upd_en) begin
            areg_q[upd_idx] <= upd_val;
         end
         if (wr_en) begin
            unique case (wr_sel)
               SEL_ADDR: areg_q[wr_idx] <= wr_data;
               SEL_OFF:  oreg_q[wr_idx] <= wr_data;
               SEL_MOD:  mreg_q[wr_idx] <= wr_data;
               default:  ;
            endcase
         end
      end
   end

   assign rd_addr = areg_q[rd_idx];
   assign rd_off  = oreg_q[rd_idx];
   assign rd_mod  = mreg_q[rd_idx];

   // R2: a stepped value lands in its register unless a write overrides it
   p_upd_wb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !(wr_en && wr_sel == SEL_ADDR && wr_idx == upd_idx))
      |=> areg_q[$past(upd_idx)] == $past(upd_val));

   // R9: a write to an address register always takes effect
   p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_ADDR) |=> areg_q[$past(wr_idx)] == $past(wr_data));

   // R11: without update or write, the address registers keep their values
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_en && !wr_en) |=> $stable(areg_q));

endmodule

// File: rtl/eagu_stepper.sv
module eagu_stepper #(
   parameter int unsigned AW     = 32,
   parameter bit          MOD_EN = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] modv,
   input  logic          dn,
   output logic [AW-1:0] nxt
);

   logic [AW-1:0] lin_nxt;
   assign lin_nxt = dn ? (cur - 1'b1) : (cur + 1'b1);

   generate
      if (MOD_EN) begin : g_circ
         logic [AW-1:0] span;
         logic [AW-1:0] low;
         logic [AW-1:0] low_nxt;
         logic          is_lin;

         always_comb begin
            span = modv;
            for (int sh = 1; sh < int'(AW); sh = sh * 2) begin
               span = span | (span >> sh);
            end
         end

         assign is_lin = &modv;
         assign low    = cur & span;

         always_comb begin
            if (dn) begin
               low_nxt = (low == '0) ? modv : (low - 1'b1);
            end else begin
               low_nxt = (low == modv) ? '0 : ((low + 1'b1) & span);
            end
         end

         assign nxt = is_lin ? lin_nxt : ((cur & ~span) | low_nxt);
      end else begin : g_lin
         logic unused_mod;
         assign unused_mod = ^modv;
         assign nxt = lin_nxt;
      end
   endgenerate

endmodule

// File: rtl/eagu_calc.sv
module eagu_calc
   import eagu_pkg::*;
#(
   parameter int unsigned AW     = 32,
   parameter int unsigned DISP_W = 15
) (
   input  logic              req_valid,
   input  mode_e             mode,
   input  logic [AW-1:0]     areg,
   input  logic [AW-1:0]     oreg,
   input  logic [AW-1:0]     stepped,
   input  logic [AW-1:0]     ext_word,
   input  logic [DISP_W-1:0] short_disp,
   input  logic [AW-1:0]     pc,
   output logic              step_dn,
   output logic              upd_en,
   output logic [AW-1:0]     ea
);

   localparam int unsigned SX_W = AW - DISP_W;

   logic [AW-1:0] disp_sx;
   assign disp_sx = {{SX_W{short_disp[DISP_W-1]}}, short_disp};

   assign step_dn = (mode == MD_PREDEC);
   assign upd_en  = req_valid && (mode == MD_POSTINC || mode == MD_PREDEC);

   always_comb begin
      unique case (mode)
         MD_POSTINC: ea = areg;
         MD_PREDEC:  ea = stepped;
         MD_LDISP:   ea = areg + ext_word;
         MD_PCLONG:  ea = pc + ext_word;
         MD_PCSHORT: ea = pc + disp_sx;
         MD_PCREG:   ea = areg + pc;
         MD_RDOFF:   ea = oreg;
         default:    ea = areg;
      endcase
   end

endmodule

// File: rtl/eagu_top.sv
module eagu_top
   import eagu_pkg::*;
#(
   parameter int unsigned NREG   = 8,
   parameter int unsigned AW     = 32,
   parameter int unsigned DISP_W = 15,
   parameter bit          MOD_EN = 1'b1,
   localparam int unsigned IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_mode,
   input  logic [IW-1:0]     req_idx,
   input  logic [AW-1:0]     ext_word,
   input  logic [DISP_W-1:0] short_disp,
   input  logic [AW-1:0]     pc,
   output logic [AW-1:0]     ea,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [IW-1:0]     wr_idx,
   input  logic [AW-1:0]     wr_data
);

   generate
      if (DISP_W >= AW || DISP_W < 2) begin : g_chk_disp
         $error("eagu_top: DISP_W must lie between 2 and AW-1");
      end
      if (AW < 8) begin : g_chk_aw
         $error("eagu_top: AW must be at least 8");
      end
   endgenerate

   mode_e         mode;
   logic [AW-1:0] rd_addr, rd_off, rd_mod, stepped;
   logic          step_dn, upd_en;

   assign mode = mode_e'(req_mode);

   eagu_regbank #(.NREG(NREG), .AW(AW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wsel_e'(wr_sel)),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .upd_en  (upd_en),
      .upd_idx (req_idx),
      .upd_val (stepped),
      .rd_idx  (req_idx),
      .rd_addr (rd_addr),
      .rd_off  (rd_off),
      .rd_mod  (rd_mod)
   );

   eagu_stepper #(.AW(AW), .MOD_EN(MOD_EN)) u_step (
      .cur  (rd_addr),
      .modv (rd_mod),
      .dn   (step_dn),
      .nxt  (stepped)
   );

   eagu_calc #(.AW(AW), .DISP_W(DISP_W)) u_calc (
      .req_valid  (req_valid),
      .mode       (mode),
      .areg       (rd_addr),
      .oreg       (rd_off),
      .stepped    (stepped),
      .ext_word   (ext_word),
      .short_disp (short_disp),
      .pc         (pc),
      .step_dn    (step_dn),
      .upd_en     (upd_en),
      .ea         (ea)
   );

   // R1: the predecrement address equals the value written back
   p_predec_ea_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode == MD_PREDEC) |-> ea == stepped);

   // R7: non-stepping modes never request an update
   p_noupd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_POSTINC && mode != MD_PREDEC) |-> !upd_en);

   // R5: a zero short displacement yields the program counter
   p_pcshort_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PCSHORT && short_disp == '0) |-> ea == pc);

   generate
      if (MOD_EN) begin : g_circ_chk
         // R4: a circular step moves only bits inside the buffer
         p_mod_inbuf_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && !rd_mod[AW-1])
            |-> (stepped ^ rd_addr) <= {rd_mod[AW-2:0], 1'b1});
      end
   endgenerate

endmodule

// File: tb/eagu_top_test.sv
module eagu_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = 3'd6;
   logic [2:0]  req_idx = 3'd0;
   logic [31:0] ext_word = 32'd0;
   logic [14:0] short_disp = 15'd0;
   logic [31:0] pc = 32'd0;
   logic [31:0] ea;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [2:0]  wr_idx = 3'd0;
   logic [31:0] wr_data = 32'd0;

   int n_checks = 0;
   int n_errors = 0;
   string force_tag = "";

   logic [31:0] m_addr [8];
   logic [31:0] m_off  [8];
   logic [31:0] m_mod  [8];

   always #2 clk = ~clk;

   eagu_top uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_idx(req_idx), .ext_word(ext_word), .short_disp(short_disp),
      .pc(pc), .ea(ea), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data)
   );

   function automatic logic [31:0] model_step(logic [31:0] a, logic [31:0] m, bit dn);
      longint size, mask, low, base;
      if (m == 32'hFFFF_FFFF) return dn ? a - 32'd1 : a + 32'd1;
      size = 1;
      while (size < longint'(m) + 1) size = size * 2;
      mask = size - 1;
      low  = longint'(a) & mask;
      base = longint'(a) - low;
      if (dn) low = (low == 0) ? longint'(m) : low - 1;
      else    low = (low == longint'(m)) ? 0 : ((low + 1) % size);
      return 32'(base + low);
   endfunction

   function automatic logic [31:0] model_ea();
      logic [31:0] r;
      logic [31:0] sx;
      r  = m_addr[req_idx];
      sx = {{17{short_disp[14]}}, short_disp};
      case (req_mode)
         3'd0: return r;
         3'd1: return model_step(r, m_mod[req_idx], 1'b1);
         3'd2: return r + ext_word;
         3'd3: return pc + ext_word;
         3'd4: return pc + sx;
         3'd5: return r + pc;
         3'd7: return m_off[req_idx];
         default: return r;
      endcase
   endfunction

   function automatic string mode_tag();
      if (force_tag != "") return force_tag;
      if (!req_valid) return "R11";
      case (req_mode)
         3'd0: return (m_mod[req_idx] != 32'hFFFF_FFFF) ? "R4" : "R2";
         3'd1: return (m_mod[req_idx] != 32'hFFFF_FFFF) ? "R4" : "R1";
         3'd2: return "R3";
         3'd3: return "R6";
         3'd4: return "R5";
         3'd5: return "R7";
         default: return "R8";
      endcase
   endfunction

   // apply current inputs: compare ea, then advance the model at the edge
   task automatic cycle();
      logic [31:0] exp_v;
      logic [31:0] nxt;
      bit          upd;
      #1;
      exp_v = model_ea();
      n_checks++;
      if (ea !== exp_v) begin
         n_errors++;
         $display("FAIL %s mode=%0d idx=%0d actual=%h expected=%h",
                  mode_tag(), req_mode, req_idx, ea, exp_v);
      end
      upd = req_valid && (req_mode == 3'd0 || req_mode == 3'd1);
      nxt = model_step(m_addr[req_idx], m_mod[req_idx], req_mode == 3'd1);
      @(posedge clk);
      if (upd) m_addr[req_idx] = nxt;
      if (wr_en) begin
         case (wr_sel)
            2'd0: m_addr[wr_idx] = wr_data;
            2'd1: m_off[wr_idx]  = wr_data;
            2'd2: m_mod[wr_idx]  = wr_data;
            default: ;
         endcase
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic req(input logic v, input logic [2:0] md, input logic [2:0] ix);
      req_valid = v; req_mode = md; req_idx = ix;
      cycle();
   endtask

   task automatic wr(input logic [1:0] s, input logic [2:0] ix, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_idx = ix; wr_data = d;
      req_valid = 1'b0; req_mode = 3'd6; req_idx = ix;
      cycle();
   endtask

   initial begin
      #(4 * 200000);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_addr[i] = 32'd0; m_off[i] = 32'd0; m_mod[i] = 32'hFFFF_FFFF;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state of every set
      force_tag = "R10";
      for (int i = 0; i < 8; i++) begin
         req(1'b0, 3'd6, 3'(i));
         req(1'b0, 3'd7, 3'(i));
      end
      req(1'b1, 3'd1, 3'd0);   // linear after reset: 0 - 1
      req(1'b0, 3'd6, 3'd0);
      force_tag = "";

      // R9: write port, ignored select, collision priority
      force_tag = "R9";
      wr(2'd0, 3'd3, 32'h0000_1000);
      wr(2'd1, 3'd3, 32'h0000_0055);
      req(1'b0, 3'd6, 3'd3);
      req(1'b0, 3'd7, 3'd3);
      wr(2'd3, 3'd3, 32'hDEAD_BEEF);
      req(1'b0, 3'd6, 3'd3);
      req(1'b0, 3'd7, 3'd3);
      wr_en = 1'b1; wr_sel = 2'd0; wr_idx = 3'd3; wr_data = 32'h0000_2000;
      req(1'b1, 3'd0, 3'd3);
      req(1'b0, 3'd6, 3'd3);
      force_tag = "";

      // R1: predecrement with a nonzero offset register present
      req(1'b1, 3'd1, 3'd3);
      req(1'b0, 3'd6, 3'd3);

      // R4: circular wrap both ways, modulus 10 in a 16-word buffer
      wr(2'd2, 3'd2, 32'd9);
      wr(2'd0, 3'd2, 32'h0000_0109);
      req(1'b1, 3'd0, 3'd2);
      force_tag = "R4";
      req(1'b0, 3'd6, 3'd2);
      force_tag = "";
      req(1'b1, 3'd1, 3'd2);
      force_tag = "R4";
      req(1'b0, 3'd6, 3'd2);
      force_tag = "";

      // R11: no stepping while not valid
      req(1'b0, 3'd0, 3'd2);
      force_tag = "R11";
      req(1'b0, 3'd6, 3'd2);
      force_tag = "";

      // R5, R6, R7, R3: displacement modes
      pc = 32'h0000_4000; ext_word = 32'hFFFF_FFF0;
      short_disp = 15'd0;      req(1'b1, 3'd4, 3'd0);
      short_disp = 15'h7FFF;   req(1'b1, 3'd4, 3'd0);
      short_disp = 15'h4000;   req(1'b1, 3'd4, 3'd0);
      short_disp = 15'h3FFF;   req(1'b1, 3'd4, 3'd0);
      req(1'b1, 3'd3, 3'd0);
      req(1'b1, 3'd5, 3'd3);
      req(1'b1, 3'd2, 3'd3);
      force_tag = "R7";
      req(1'b0, 3'd6, 3'd3);
      force_tag = "";

      // random traffic with small modifiers and edge-near addresses
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         r = $urandom;
         pc         = $urandom;
         ext_word   = $urandom;
         short_disp = 15'($urandom);
         if (r % 7 == 0) begin
            wr_en  = 1'b1;
            wr_sel = 2'($urandom);
            wr_idx = 3'($urandom);
            if (wr_sel == 2'd2)
               wr_data = ($urandom % 3 == 0) ? 32'hFFFF_FFFF : ($urandom % 40);
            else
               wr_data = ($urandom % 2 == 0) ? $urandom : ($urandom % 64);
         end
         req_valid = ($urandom % 5 != 0);
         req_mode  = 3'($urandom);
         req_idx   = ($urandom % 2 == 0) ? wr_idx : 3'($urandom);
         cycle();
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule